// File: doc/BRIEF.md
# Memory tag check unit

This unit sits in front of a data memory port and enforces lock-and-key tagging on every load and store. A private tag array holds one 4-bit lock for each aligned 16-byte granule. Each pointer carries a 4-bit key in bits [59:56]. On every access the unit reads the lock of the addressed granule and compares it with the key. The access then either goes on to memory or is reported as a tag fault.

How a mismatch is reported depends on a mode register. In precise mode the access is dropped and the faulting pointer is returned. In deferred mode the access goes ahead, a sticky flag is raised, and one report without an address is given at the next kernel-entry strobe. Split mode handles loads precisely and stores in the deferred way. A small command port writes the lock of one granule, writes the lock and zeroes the granule's data, stamps a run of granules at one per cycle, or reads a lock back. The tag array can be reached only through this port.

Top module: `tagchk_unit`

## Requirements
- R1: After reset, acc_grant, sync_fault, mem_req, rd_valid, busy, async_pending and async_report are low, cmd_ready is high, and the mode is precise.
- R2: Bits [59:56] of acc_ptr are the key. The granule index is acc_ptr[PA_W-1:4]: the low 4 bits select a byte within the granule and bits [63:PA_W] other than the key are ignored. mem_addr is acc_ptr[PA_W-1:0].
- R3: An access accepted at clock edge E with a matching key gives a one-cycle pulse on acc_grant and mem_req after edge E+1. mem_we, mem_addr and mem_wdata carry the access.
- R4: In precise mode (mode code 0, and code 3 behaves the same), a mismatch pulses sync_fault after edge E+1 with no acc_grant and no mem_req, and loads the full 64-bit pointer into fault_addr.
- R5: In deferred mode (code 1), a mismatch is granted and sets async_pending. async_pending stays set until async_clr. A kentry strobe while it is set gives exactly one async_report pulse on the next cycle, and later strobes give none until a clear.
- R6: In split mode (code 2), a mismatching load is handled as in R4 and a mismatching store as in R5.
- R7: An access passes unchecked if chk_en was low when it was accepted, or if bypass_f was high and the key was 4'hF.
- R8: cmd_op codes: 0 sets one lock, 1 sets the lock and zeroes the data, 2 stamps a range, 3 reads a lock. A read accepted at edge E gives rd_valid and rd_tag after E.
- R9: Command 1 also issues a single memory write: mem_req and mem_we high, mem_addr = {cmd_gran, 4'b0}, mem_wdata = 0, after the accept edge.
- R10: Command 2 writes cmd_tag into cmd_count consecutive granules from cmd_gran, one per cycle. The index wraps at the top of the array. busy is high for exactly cmd_count cycles, and acc_ready and cmd_ready are low during that time. A count of 0 changes nothing.
- R11: Data stores never change a lock.
- R12: acc_grant and sync_fault are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Mode code: 0 precise, 1 deferred, 2 split, 3 precise |
| chk_en | input | 1 | Global check enable |
| bypass_f | input | 1 | Key 4'hF matches any lock when high |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_write | input | 1 | 1 store, 0 load |
| acc_ptr | input | 64 | Tagged pointer |
| acc_wdata | input | DATA_W | Store data |
| acc_grant | output | 1 | Access passed the check |
| sync_fault | output | 1 | Precise tag fault pulse |
| fault_addr | output | 64 | Pointer of the last precise fault |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PA_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| kentry | input | 1 | Kernel-entry strobe |
| async_clr | input | 1 | Clears the deferred flag |
| async_pending | output | 1 | Sticky deferred-mismatch flag |
| async_report | output | 1 | Deferred fault report pulse |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Command code (R8) |
| cmd_gran | input | GI_W | Granule index |
| cmd_tag | input | 4 | Lock value |
| cmd_count | input | GI_W+1 | Range length |
| busy | output | 1 | Range stamping in progress |
| rd_valid | output | 1 | Read result valid |
| rd_tag | output | 4 | Read lock value |

## Verification
The assertions assume the environment holds cmd_valid and acc_valid only when the matching ready is high, and that the mode is not rewritten while an access is in flight. They also treat kentry and async_clr as strobes. The bench drives every request on the falling edge, holds it for one cycle only when ready is high, and changes the mode only while the pipeline is empty. Locks are written before any access that reads them, so no check depends on uninitialised array contents.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  typedef enum logic [1:0] {
    MODE_PRECISE = 2'd0,
    MODE_DEFER   = 2'd1,
    MODE_SPLIT   = 2'd2,
    MODE_PRECISE2 = 2'd3
  } chk_mode_e;

  typedef enum logic [1:0] {
    OP_SET     = 2'd0,
    OP_SETZERO = 2'd1,
    OP_RANGE   = 2'd2,
    OP_READ    = 2'd3
  } tag_op_e;

  localparam int KEY_HI = 59;
  localparam int KEY_LO = 56;
  localparam logic [3:0] KEY_ANY = 4'hF;
endpackage

// File: rtl/tagchk_store.sv
module tagchk_store #(
  parameter int GI_W = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [GI_W-1:0] waddr,
  input  logic [3:0]      wtag,
  input  logic [GI_W-1:0] raddr,
  output logic [3:0]      rtag
);
  localparam int GRANS = 1 << GI_W;
  logic [3:0] lock_mem [GRANS];

  always_ff @(posedge clk) begin
    if (we) lock_mem[waddr] <= wtag;
    rtag <= lock_mem[raddr];
  end
endmodule

// File: rtl/tagchk_range.sv
module tagchk_range #(
  parameter int GI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [GI_W-1:0] first,
  input  logic [GI_W:0]   count,
  input  logic [3:0]      tag,
  output logic            busy,
  output logic            wr_en,
  output logic [GI_W-1:0] wr_idx,
  output logic [3:0]      wr_tag
);
  localparam logic [GI_W-1:0] STEP = GI_W'(1);
  localparam logic [GI_W:0]   LAST = (GI_W+1)'(1);

  logic [GI_W-1:0] idx_q;
  logic [GI_W:0]   left_q;
  logic [3:0]      tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      tag_q  <= '0;
    end else if (busy) begin
      idx_q  <= idx_q + STEP;
      left_q <= left_q - LAST;
      if (left_q == LAST) busy <= 1'b0;
    end else if (start && count != '0) begin
      busy   <= 1'b1;
      idx_q  <= first;
      left_q <= count;
      tag_q  <= tag;
    end
  end

  assign wr_en  = busy;
  assign wr_idx = idx_q;
  assign wr_tag = tag_q;
endmodule

// File: rtl/tagchk_defer.sv
module tagchk_defer (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic kentry,
  output logic pending,
  output logic report
);
  logic told_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      told_q  <= 1'b0;
      report  <= 1'b0;
    end else begin
      report <= kentry && pending && !told_q && !clr;
      if (clr) begin
        pending <= 1'b0;
        told_q  <= 1'b0;
      end else begin
        if (set) pending <= 1'b1;
        if (kentry && pending) told_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tagchk_unit.sv
module tagchk_unit
  import tagchk_pkg::*;
#(
  parameter int GI_W   = 6,
  parameter int DATA_W = 128,
  localparam int PA_W  = GI_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic              chk_en,
  input  logic              bypass_f,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [63:0]       acc_ptr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_grant,
  output logic              sync_fault,
  output logic [63:0]       fault_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              kentry,
  input  logic              async_clr,
  output logic              async_pending,
  output logic              async_report,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [GI_W-1:0]   cmd_gran,
  input  logic [3:0]        cmd_tag,
  input  logic [GI_W:0]     cmd_count,
  output logic              busy,
  output logic              rd_valid,
  output logic [3:0]        rd_tag
);
  chk_mode_e mode_q;

  logic              s1_valid, s1_write, s1_chk, s1_byp;
  logic [63:0]       s1_ptr;
  logic [DATA_W-1:0] s1_wdata;

  logic              cmd_fire, acc_fire;
  logic [GI_W-1:0]   rd_idx, wr_idx, rng_idx;
  logic [3:0]        wr_tag, rng_tag, lock_q;
  logic              wr_en, rng_en;
  logic              mismatch, precise, defer_set;
  logic [3:0]        key;

  assign cmd_ready = !busy && !s1_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign acc_ready = !busy && !cmd_valid;
  assign acc_fire  = acc_valid && acc_ready;

  // one read port shared by commands and accesses (they never fire together)
  assign rd_idx = cmd_fire ? cmd_gran : acc_ptr[PA_W-1:4];
  assign wr_en  = rng_en || (cmd_fire && (cmd_op == OP_SET || cmd_op == OP_SETZERO));
  assign wr_idx = rng_en ? rng_idx : cmd_gran;
  assign wr_tag = rng_en ? rng_tag : cmd_tag;

  tagchk_store #(.GI_W(GI_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wtag(wr_tag),
    .raddr(rd_idx), .rtag(lock_q)
  );

  tagchk_range #(.GI_W(GI_W)) u_range (
    .clk(clk), .rst(rst),
    .start(cmd_fire && cmd_op == OP_RANGE),
    .first(cmd_gran), .count(cmd_count), .tag(cmd_tag),
    .busy(busy), .wr_en(rng_en), .wr_idx(rng_idx), .wr_tag(rng_tag)
  );

  // check stage: compares the key with the lock read in the previous cycle
  assign key       = s1_ptr[KEY_HI:KEY_LO];
  assign mismatch  = s1_valid && s1_chk && !(s1_byp && key == KEY_ANY) && key != lock_q;
  assign precise   = (mode_q == MODE_PRECISE) || (mode_q == MODE_PRECISE2) ||
                     (mode_q == MODE_SPLIT && !s1_write);
  assign defer_set = mismatch && !precise;

  tagchk_defer u_defer (
    .clk(clk), .rst(rst), .set(defer_set), .clr(async_clr), .kentry(kentry),
    .pending(async_pending), .report(async_report)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_PRECISE;
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_chk   <= 1'b0;
      s1_byp   <= 1'b0;
      s1_ptr   <= '0;
      s1_wdata <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (mode_we) mode_q <= chk_mode_e'(mode_wdata);
      s1_valid <= acc_fire;
      if (acc_fire) begin
        s1_write <= acc_write;
        s1_chk   <= chk_en;
        s1_byp   <= bypass_f;
        s1_ptr   <= acc_ptr;
        s1_wdata <= acc_wdata;
      end
      rd_valid <= cmd_fire && cmd_op == OP_READ;
    end
  end

  assign rd_tag = lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_grant  <= 1'b0;
      sync_fault <= 1'b0;
      fault_addr <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      acc_grant  <= 1'b0;
      sync_fault <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      if (s1_valid) begin
        if (mismatch && precise) begin
          sync_fault <= 1'b1;
          fault_addr <= s1_ptr;
        end else begin
          acc_grant <= 1'b1;
          mem_req   <= 1'b1;
          mem_we    <= s1_write;
          mem_addr  <= s1_ptr[PA_W-1:0];
          mem_wdata <= s1_wdata;
        end
      end else if (cmd_fire && cmd_op == OP_SETZERO) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= {cmd_gran, 4'b0};
        mem_wdata <= '0;
      end
    end
  end
endmodule

// File: rtl/tagchk_unit_chk.sv
module tagchk_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_grant,
  input logic       sync_fault,
  input logic       mem_req,
  input logic       busy,
  input logic       kentry,
  input logic       async_clr,
  input logic       async_pending,
  input logic       async_report,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rd_valid
);
  p_grant_fault_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(acc_grant && sync_fault));

  p_fault_blocks_mem_r4: assert property (@(posedge clk) disable iff (rst)
    sync_fault |-> !mem_req);

  p_busy_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !acc_grant);

  p_pending_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(async_pending) && !$past(async_clr)) |-> async_pending);

  p_report_after_kentry_r5: assert property (@(posedge clk) disable iff (rst)
    async_report |-> $past(kentry));

  p_report_once_r5: assert property (@(posedge clk) disable iff (rst)
    async_report |=> !async_report);

  p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd3));
endmodule

bind tagchk_unit tagchk_unit_chk u_chk (
  .clk(clk), .rst(rst), .acc_grant(acc_grant), .sync_fault(sync_fault),
  .mem_req(mem_req), .busy(busy), .kentry(kentry), .async_clr(async_clr),
  .async_pending(async_pending), .async_report(async_report),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .rd_valid(rd_valid)
);

// File: tb/tagchk_unit_tb.sv
module tagchk_unit_tb;
  localparam int GI_W = 6;
  localparam int DATA_W = 128;
  localparam int PA_W = GI_W + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic mode_we = 0; logic [1:0] mode_wdata = 0;
  logic chk_en = 1, bypass_f = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [63:0] acc_ptr = 0;
  logic [DATA_W-1:0] acc_wdata = 0;
  logic kentry = 0, async_clr = 0;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0;
  logic [GI_W-1:0] cmd_gran = 0; logic [3:0] cmd_tag = 0;
  logic [GI_W:0] cmd_count = 0;
  logic acc_ready, acc_grant, sync_fault, mem_req, mem_we;
  logic [63:0] fault_addr;
  logic [PA_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic async_pending, async_report, cmd_ready, busy, rd_valid;
  logic [3:0] rd_tag;

  tagchk_unit #(.GI_W(GI_W), .DATA_W(DATA_W)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkptr(input logic [3:0] key, input logic [PA_W-1:0] a);
    return {4'hA, key, 46'h0, a} | 64'h0000_1230_0000_0000;
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  // result visible at the second falling edge after drive
  task automatic access(input logic wr, input logic [63:0] p, input logic [DATA_W-1:0] d);
    @(negedge clk); acc_valid = 1; acc_write = wr; acc_ptr = p; acc_wdata = d;
    @(negedge clk); acc_valid = 0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [GI_W-1:0] g, input logic [3:0] t, input logic [GI_W:0] n);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_gran = g; cmd_tag = t; cmd_count = n;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic read_chk(input logic [GI_W-1:0] g, input logic [3:0] exp, input string req);
    cmd(2'd3, g, 4'h0, '0);
    chk(rd_valid === 1'b1, req, 64'(rd_valid), 64'd1);
    chk(rd_tag === exp, req, 64'(rd_tag), 64'(exp));
  endtask

  task automatic t_reset;
    chk(acc_grant === 0 && sync_fault === 0 && mem_req === 0, "R1 outs", {61'b0, acc_grant, sync_fault, mem_req}, 0);
    chk(busy === 0 && rd_valid === 0 && async_pending === 0 && async_report === 0, "R1 status",
        {60'b0, busy, rd_valid, async_pending, async_report}, 0);
    chk(cmd_ready === 1, "R1 cmd_ready", 64'(cmd_ready), 1);
  endtask

  task automatic t_set_read;
    cmd(2'd0, 6'd3, 4'h5, '0);
    cmd(2'd0, 6'd2, 4'h4, '0);
    cmd(2'd0, 6'd5, 4'h1, '0);
    read_chk(6'd3, 4'h5, "R8 set/read");
  endtask

  task automatic t_pass;
    logic [63:0] p = mkptr(4'h5, 10'h03A);
    access(1'b1, p, 128'hBEEF);
    chk(acc_grant === 1 && mem_req === 1 && mem_we === 1, "R3 grant store", {61'b0, acc_grant, mem_req, mem_we}, 7);
    chk(mem_addr === 10'h03A, "R2 mem_addr", 64'(mem_addr), 64'h3A);
    chk(mem_wdata === 128'hBEEF, "R3 wdata", mem_wdata[63:0], 64'hBEEF);
    access(1'b0, mkptr(4'h5, 10'h030), '0);
    chk(acc_grant === 1 && mem_we === 0, "R2 low bits ignored load", {62'b0, acc_grant, mem_we}, 2);
  endtask

  task automatic t_sync;
    logic [63:0] p = mkptr(4'h6, 10'h035);
    access(1'b0, p, '0);
    chk(sync_fault === 1 && acc_grant === 0, "R4/R12 sync load", {62'b0, sync_fault, acc_grant}, 2);
    chk(fault_addr === p, "R4 fault_addr", fault_addr, p);
    access(1'b1, mkptr(4'h7, 10'h031), 128'h1);
    chk(sync_fault === 1 && mem_req === 0, "R4 sync store blocked", {62'b0, sync_fault, mem_req}, 2);
    chk(async_pending === 0, "R4 no pending", 64'(async_pending), 0);
  endtask

  task automatic t_async;
    int reps = 0;
    set_mode(2'd1);
    access(1'b1, mkptr(4'h9, 10'h036), 128'h2);
    chk(acc_grant === 1 && sync_fault === 0, "R5 async grant", {62'b0, acc_grant, sync_fault}, 2);
    chk(async_pending === 1, "R5 pending", 64'(async_pending), 1);
    access(1'b0, mkptr(4'h9, 10'h036), '0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); kentry = 1;
      @(negedge clk); kentry = 0;
      if (async_report === 1) reps++;
    end
    chk(reps == 1, "R5 one report", 64'(reps), 1);
    chk(async_pending === 1, "R5 sticky", 64'(async_pending), 1);
    @(negedge clk); async_clr = 1;
    @(negedge clk); async_clr = 0;
    chk(async_pending === 0, "R5 clear", 64'(async_pending), 0);
  endtask

  task automatic t_split;
    set_mode(2'd2);
    access(1'b0, mkptr(4'h8, 10'h030), '0);
    chk(sync_fault === 1 && acc_grant === 0, "R6 split load precise", {62'b0, sync_fault, acc_grant}, 2);
    access(1'b1, mkptr(4'h8, 10'h030), 128'h3);
    chk(acc_grant === 1 && async_pending === 1, "R6 split store deferred", {62'b0, acc_grant, async_pending}, 3);
    @(negedge clk); async_clr = 1;
    @(negedge clk); async_clr = 0;
    set_mode(2'd0);
  endtask

  task automatic t_bypass;
    chk_en = 0;
    access(1'b0, mkptr(4'h2, 10'h030), '0);
    chk(acc_grant === 1, "R7 chk_en low", 64'(acc_grant), 1);
    chk_en = 1; bypass_f = 1;
    access(1'b0, mkptr(4'hF, 10'h030), '0);
    chk(acc_grant === 1, "R7 match-all", 64'(acc_grant), 1);
    bypass_f = 0;
    access(1'b0, mkptr(4'hF, 10'h030), '0);
    chk(sync_fault === 1, "R7 no bypass faults", 64'(sync_fault), 1);
  endtask

  task automatic t_zero;
    @(negedge clk); cmd_valid = 1; cmd_op = 2'd1; cmd_gran = 6'd7; cmd_tag = 4'h2;
    @(negedge clk); cmd_valid = 0;
    chk(mem_req === 1 && mem_we === 1 && mem_addr === 10'h070 && mem_wdata === '0, "R9 zero write",
        {52'b0, mem_req, mem_we, mem_addr}, {52'b0, 2'b11, 10'h070});
    read_chk(6'd7, 4'h2, "R9 tag set");
  endtask

  task automatic t_range;
    int n = 0;
    bit rdy_bad = 0;
    cmd(2'd2, 6'd62, 4'h9, 7'd4);
    while (busy === 1 && n < 100) begin
      n++;
      if (acc_ready !== 0 || cmd_ready !== 0) rdy_bad = 1;
      @(negedge clk);
    end
    chk(n == 4, "R10 busy cycles", 64'(n), 4);
    chk(!rdy_bad, "R10 ready low while busy", 64'(rdy_bad), 0);
    read_chk(6'd62, 4'h9, "R10 first");
    read_chk(6'd63, 4'h9, "R10 top");
    read_chk(6'd0, 4'h9, "R10 wrap");
    read_chk(6'd1, 4'h9, "R10 last");
    read_chk(6'd2, 4'h4, "R10 past end untouched");
    cmd(2'd2, 6'd5, 4'h9, 7'd0);
    chk(busy === 0, "R10 zero count idle", 64'(busy), 0);
    read_chk(6'd5, 4'h1, "R10 zero count no write");
  endtask

  task automatic t_isolation;
    chk_en = 0;
    access(1'b1, mkptr(4'hC, 10'h03F), {DATA_W{1'b1}});
    chk_en = 1;
    read_chk(6'd3, 4'h5, "R11 store leaves tag");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_set_read;
    t_pass;
    t_sync;
    t_async;
    t_split;
    t_bypass;
    t_zero;
    t_range;
    t_isolation;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule